// File: doc/BRIEF.md
# Predicated Flag-Setting ALU

This block is one stage of a 32-bit integer datapath. Each cycle that `inValid` is high it takes two operands, an operation code, a set-flags request, a 4-bit condition field and the carry-out of an external shift of the second operand. It computes an add, subtract, compare, compare-negative, move or bitwise result. It also keeps the four status flags (negative, zero, carry, overflow) in a register of its own.

Before anything commits, the condition field is tested against the flags already held in that register. A failed test turns the operation into a no-op: no register write, no flag change. A passing operation writes the result and raises a write-enable pulse, unless it is a compare. A compare only updates the flags. Flags change only on request, or always for compares, so any number of operations that do not set flags can sit between the flag producer and a conditional consumer.

Top module: `cond_alu`

## Requirements
- R1: Operation codes on `opSel` are: 000 add (A+B), 001 subtract (A-B), 010 compare (as subtract), 011 compare-negative (as add), 100 move (B), 101 AND, 110 OR, 111 XOR.
- R2: For add and compare-negative, C is set exactly when the unsigned sum is 2^32 or more. V is set when two operands of equal sign give a result of the other sign.
- R3: For subtract and compare, C is set when A >= B unsigned, meaning no borrow, and cleared on a borrow. V is set when A and B differ in sign and the result's sign differs from A's.
- R4: `flags` is {N,Z,C,V} in bits 3..0. On a flag update, N is result bit 31 and Z is set when all 32 result bits are zero.
- R5: For move and bitwise operations with a flag update, C takes `shiftCarry` and V keeps its previous value.
- R6: Compare and compare-negative update all four flags whether or not `setFlags` is high, and never assert `regWrite` or change `result`.
- R7: A non-compare operation with `setFlags` low leaves `flags` unchanged.
- R8: The condition on `condCode` is evaluated against the registered flags. The codes are: 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V), and 1110 and 1111 always.
- R9: When the condition fails, `regWrite` stays low, `result` and `flags` keep their values.
- R10: A committed operation shows its effect on the clock edge where `inValid` is sampled high. `regWrite` is high for exactly that one cycle, and a cycle with `inValid` low changes nothing.
- R11: A synchronous reset clears `flags`, `result` and `regWrite` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation present this cycle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand (already shifted) |
| opSel | input | 3 | Operation code |
| setFlags | input | 1 | Request flag update |
| condCode | input | 4 | Condition field |
| shiftCarry | input | 1 | Carry-out of the operand shift |
| result | output | 32 | Registered result |
| regWrite | output | 1 | Destination write pulse |
| flags | output | 4 | Status register {N,Z,C,V} |

## Verification
The bench targets the carry sense of subtraction. A design that treats C as a borrow flag would report C clear for 5-5 and set for 0-1. It also covers signed overflow at 0x7FFFFFFF+1 and 0x80000000-1, where a wrong V formula misses the sign flip. Compares issued with `setFlags` low catch a design that gates compare flags on the request or lets compares write a result. Conditional operations follow both flag-setting and plain operations, which exposes a design that takes conditions from in-flight values rather than the stored flags or lets a failed condition touch the flags.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;
  localparam int DATA_W = 32;
  localparam int OP_W   = 3;
  localparam int COND_W = 4;

  localparam logic [OP_W-1:0] OP_ADD = 3'd0;
  localparam logic [OP_W-1:0] OP_SUB = 3'd1;
  localparam logic [OP_W-1:0] OP_CMP = 3'd2;
  localparam logic [OP_W-1:0] OP_CMN = 3'd3;
  localparam logic [OP_W-1:0] OP_MOV = 3'd4;
  localparam logic [OP_W-1:0] OP_AND = 3'd5;
  localparam logic [OP_W-1:0] OP_ORR = 3'd6;
  localparam logic [OP_W-1:0] OP_EOR = 3'd7;

  // flag bit positions inside the status register
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FC = 1;
  localparam int FV = 0;

  typedef struct packed {
    logic wrEn;    // commit result and pulse write-enable
    logic flagEn;  // commit new flags
    logic arith;   // adder path selected
    logic isSub;   // invert second operand and add one
  } ctrlStrobe_t;
endpackage

// File: rtl/cond_alu_ctrl.sv
module cond_alu_ctrl
  import cond_alu_pkg::*;
(
  input  logic              inValid,
  input  logic [OP_W-1:0]   opSel,
  input  logic              setFlags,
  input  logic [COND_W-1:0] condCode,
  input  logic [3:0]        curFlags,
  output ctrlStrobe_t       strobe
);
  logic nF, zF, cF, vF;
  logic condPass;
  logic isCompare;

  assign nF = curFlags[FN];
  assign zF = curFlags[FZ];
  assign cF = curFlags[FC];
  assign vF = curFlags[FV];

  always_comb begin
    unique case (condCode)
      4'b0000: condPass = zF;
      4'b0001: condPass = !zF;
      4'b0010: condPass = cF;
      4'b0011: condPass = !cF;
      4'b0100: condPass = nF;
      4'b0101: condPass = !nF;
      4'b0110: condPass = vF;
      4'b0111: condPass = !vF;
      4'b1000: condPass = cF && !zF;
      4'b1001: condPass = !cF || zF;
      4'b1010: condPass = (nF == vF);
      4'b1011: condPass = (nF != vF);
      4'b1100: condPass = !zF && (nF == vF);
      4'b1101: condPass = zF || (nF != vF);
      default: condPass = 1'b1;
    endcase
  end

  assign isCompare = (opSel == OP_CMP) || (opSel == OP_CMN);

  always_comb begin
    strobe.arith  = (opSel == OP_ADD) || (opSel == OP_SUB) || isCompare;
    strobe.isSub  = (opSel == OP_SUB) || (opSel == OP_CMP);
    strobe.wrEn   = inValid && condPass && !isCompare;
    strobe.flagEn = inValid && condPass && (setFlags || isCompare);
  end
endmodule

// File: rtl/cond_alu_dp.sv
module cond_alu_dp
  import cond_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrlStrobe_t   strobe,
  input  logic [OP_W-1:0] opSel,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic          shiftCarry,
  output logic [W-1:0]  resultQ,
  output logic          writeQ,
  output logic [3:0]    flagsQ
);
  localparam int MSB = W - 1;

  logic [W-1:0] opBx;
  logic [W:0]   sumExt;
  logic [W-1:0] logicRes;
  logic [W-1:0] nextRes;
  logic         nextC;
  logic         nextV;
  logic [3:0]   nextFlags;

  assign opBx   = strobe.isSub ? ~opB : opB;
  assign sumExt = {1'b0, opA} + {1'b0, opBx} + {{W{1'b0}}, strobe.isSub};

  always_comb begin
    unique case (opSel)
      OP_AND:  logicRes = opA & opB;
      OP_ORR:  logicRes = opA | opB;
      OP_EOR:  logicRes = opA ^ opB;
      default: logicRes = opB;
    endcase
  end

  assign nextRes = strobe.arith ? sumExt[W-1:0] : logicRes;
  assign nextC   = strobe.arith ? sumExt[W] : shiftCarry;
  assign nextV   = strobe.arith
                 ? ((opA[MSB] == opBx[MSB]) && (nextRes[MSB] != opA[MSB]))
                 : flagsQ[FV];

  always_comb begin
    nextFlags     = '0;
    nextFlags[FN] = nextRes[MSB];
    nextFlags[FZ] = (nextRes == '0);
    nextFlags[FC] = nextC;
    nextFlags[FV] = nextV;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultQ <= '0;
      writeQ  <= 1'b0;
      flagsQ  <= '0;
    end else begin
      writeQ <= strobe.wrEn;
      if (strobe.wrEn)   resultQ <= nextRes;
      if (strobe.flagEn) flagsQ  <= nextFlags;
    end
  end
endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import cond_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [2:0]  opSel,
  input  logic        setFlags,
  input  logic [3:0]  condCode,
  input  logic        shiftCarry,
  output logic [31:0] result,
  output logic        regWrite,
  output logic [3:0]  flags
);
  ctrlStrobe_t strobe;

  cond_alu_ctrl u_ctrl (
    .inValid  (inValid),
    .opSel    (opSel),
    .setFlags (setFlags),
    .condCode (condCode),
    .curFlags (flags),
    .strobe   (strobe)
  );

  cond_alu_dp #(.W(DATA_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .opSel      (opSel),
    .opA        (opA),
    .opB        (opB),
    .shiftCarry (shiftCarry),
    .resultQ    (result),
    .writeQ     (regWrite),
    .flagsQ     (flags)
  );
endmodule

// File: rtl/cond_alu_chk.sv
module cond_alu_chk (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [2:0]  opSel,
  input logic        setFlags,
  input logic [3:0]  condCode,
  input logic [31:0] result,
  input logic        regWrite,
  input logic [3:0]  flags
);
  function automatic logic holds(input logic [3:0] cc, input logic [3:0] f);
    logic base;
    case (cc[3:1])
      3'd0: base = f[2];
      3'd1: base = f[1];
      3'd2: base = f[3];
      3'd3: base = f[0];
      3'd4: base = f[1] & ~f[2];
      3'd5: base = (f[3] ~^ f[0]);
      3'd6: base = ~f[2] & (f[3] ~^ f[0]);
      default: base = 1'b1;
    endcase
    return (cc[3:1] == 3'd7) ? 1'b1 : (base ^ cc[0]);
  endfunction

  logic isCmp;
  logic passNow;
  assign isCmp   = (opSel == 3'd2) || (opSel == 3'd3);
  assign passNow = holds(condCode, flags);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (flags == 4'd0) && !regWrite && (result == 32'd0)); // R11

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    inValid && isCmp |=> !regWrite && $stable(result)); // R6

  AST_NOSET_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    inValid && !isCmp && !setFlags |=> $stable(flags)); // R7

  AST_FAIL_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    inValid && !passNow |=> !regWrite && $stable(flags) && $stable(result)); // R9

  AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !regWrite && $stable(flags) && $stable(result)); // R10

  AST_NZ_TRACK: assert property (@(posedge clk) disable iff (rst)
    inValid && passNow && setFlags && !isCmp
      |=> (flags[3] == result[31]) && (flags[2] == (result == 32'd0))); // R4
endmodule

bind cond_alu cond_alu_chk u_chk (.*);

// File: tb/tb_cond_alu.sv
`timescale 1ns/1ps
module tb_cond_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [31:0] opA, opB;
  logic [2:0]  opSel;
  logic        setFlags;
  logic [3:0]  condCode;
  logic        shiftCarry;
  logic [31:0] result;
  logic        regWrite;
  logic [3:0]  flags;

  int checks = 0;
  int fails  = 0;

  logic [31:0] expRes;
  logic [3:0]  expFlags;

  always #4 clk = ~clk; // 125 MHz

  cond_alu dut (.*);

  function automatic logic condOk(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Apply one operation for one cycle and compare against the bench model.
  task automatic doOp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic sf, input logic [3:0] cc, input logic sc, input string req);
    logic [31:0] r;
    logic        c, v, pass, isCmp, arith;
    longint      sa, sb, sr;
    logic [3:0]  nf;
    logic        expWr;
    @(negedge clk);
    inValid = 1'b1; opSel = op; opA = a; opB = b; setFlags = sf; condCode = cc; shiftCarry = sc;
    pass  = condOk(cc, expFlags);
    isCmp = (op == 3'd2) || (op == 3'd3);
    arith = (op <= 3'd3);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    c = expFlags[1]; v = expFlags[0];
    case (op)
      3'd0, 3'd3: begin
        r  = a + b;
        c  = ({32'd0, a} + {32'd0, b}) >= 64'h1_0000_0000;
        sr = sa + sb;
        v  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      3'd1, 3'd2: begin
        r  = a - b;
        c  = (a >= b);
        sr = sa - sb;
        v  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
      3'd4: begin r = b; c = sc; end
      3'd5: begin r = a & b; c = sc; end
      3'd6: begin r = a | b; c = sc; end
      default: begin r = a ^ b; c = sc; end
    endcase
    if (!arith) v = expFlags[0];
    nf    = {r[31], (r == 32'd0), c, v};
    expWr = pass && !isCmp;
    @(posedge clk);
    #2;
    inValid = 1'b0;
    if (expWr) expRes = r;
    if (pass && (sf || isCmp)) expFlags = nf;
    check(req, "regWrite", {31'd0, regWrite}, {31'd0, expWr});
    check(req, "result",   result, expRes);
    check(req, "flags",    {28'd0, flags}, {28'd0, expFlags});
  endtask

  function automatic logic [31:0] pickVal();
    case ($urandom % 8)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h7FFF_FFFF;
      3: return 32'hFFFF_FFFF;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd5741);
    rst = 1'b1; inValid = 1'b0; opA = '0; opB = '0; opSel = '0;
    setFlags = 1'b0; condCode = 4'hE; shiftCarry = 1'b0;
    expRes = '0; expFlags = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R11", "reset flags",    {28'd0, flags}, 32'd0);
    check("R11", "reset result",   result, 32'd0);
    check("R11", "reset regWrite", {31'd0, regWrite}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R2 add carry and overflow corners
    doOp(3'd0, 32'h7FFF_FFFF, 32'h1, 1'b1, 4'hE, 1'b0, "R2");
    doOp(3'd0, 32'hFFFF_FFFF, 32'h1, 1'b1, 4'hE, 1'b0, "R2");
    doOp(3'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, 4'hE, 1'b0, "R2");
    // R3 subtract: equal gives C=1 Z=1; borrow gives C=0
    doOp(3'd1, 32'd5, 32'd5, 1'b1, 4'hE, 1'b0, "R3");
    doOp(3'd1, 32'd0, 32'd1, 1'b1, 4'hE, 1'b0, "R3");
    doOp(3'd1, 32'h8000_0000, 32'h1, 1'b1, 4'hE, 1'b0, "R3");
    doOp(3'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 4'hE, 1'b0, "R3");
    // R5 logical with shift carry keeps V (V is set from previous)
    doOp(3'd5, 32'hF0F0_0000, 32'h0F0F_0000, 1'b1, 4'hE, 1'b1, "R5");
    doOp(3'd4, 32'd0, 32'h8000_0000, 1'b1, 4'hF, 1'b0, "R5");
    // R6 compares with setFlags low still update flags, no write
    doOp(3'd2, 32'd9, 32'd9, 1'b0, 4'hE, 1'b0, "R6");
    doOp(3'd3, 32'h7FFF_FFFF, 32'd1, 1'b0, 4'hE, 1'b0, "R6");
    // R7 no setFlags: flags stay, result written
    doOp(3'd0, 32'd0, 32'd0, 1'b0, 4'hE, 1'b0, "R7");
    // R8/R9 condition from stored flags after intervening plain ops
    doOp(3'd2, 32'd3, 32'd3, 1'b0, 4'hE, 1'b0, "R8");     // Z=1
    doOp(3'd6, 32'd1, 32'd2, 1'b0, 4'hE, 1'b0, "R8");
    doOp(3'd0, 32'd10, 32'd20, 1'b1, 4'd0, 1'b0, "R8");   // EQ passes
    doOp(3'd0, 32'd10, 32'd20, 1'b1, 4'd0, 1'b0, "R9");   // EQ now fails
    doOp(3'd2, 32'd1, 32'd2, 1'b0, 4'd1, 1'b0, "R9");     // NE fails? Z=0 so passes
    for (int cc = 0; cc < 16; cc++)
      doOp(3'd7, 32'h1234_5678, $urandom, 1'b0, cc[3:0], 1'b0, "R8");
    // R10 idle cycle: nothing changes, write pulse drops
    @(negedge clk);
    @(posedge clk); #2;
    check("R10", "idle regWrite", {31'd0, regWrite}, 32'd0);
    check("R10", "idle result",   result, expRes);
    check("R10", "idle flags",    {28'd0, flags}, {28'd0, expFlags});

    // R1 random mix over all operations and conditions
    for (int i = 0; i < 3000; i++) begin
      doOp(3'($urandom % 8), pickVal(), pickVal(), 1'($urandom % 2),
           4'($urandom % 16), 1'($urandom % 2), "R1");
      if ($urandom % 10 == 0) begin
        @(negedge clk); @(posedge clk); #2;
        check("R10", "gap regWrite", {31'd0, regWrite}, 32'd0);
      end
    end

    // R11 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    expRes = '0; expFlags = '0;
    check("R11", "re-reset flags",  {28'd0, flags}, 32'd0);
    check("R11", "re-reset result", result, 32'd0);
    @(negedge clk); rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule